// File: doc/BRIEF.md
# Packed Run-Length Sample Stream Decoder

This block expands a compressed capture stream into logic samples. Memory words arrive 32 bits at a time over a valid/ready input, grouped in slices of nine. The first eight words of a slice hold the low 32 bits of eight 36-bit records. The ninth word packs the top four bits of all eight records. The block rebuilds each record and reads it either as a sample record or as a run-length extension for the sample before it.

A sample record carries a 34-channel value, a base run of one or two samples, and a flag. The flag says that the next record widens the run. The decoder presents each sample on its output for as many consecutive beats as its run requires, one sample per beat, with no output backpressure.

A programmable sample limit ends decoding as soon as that many samples have been produced, even part way through a run. A limit of zero means no limit. The block sits between a capture-memory reader and whatever packs samples for the host.

Top module: `rle_stream_decoder`

## Requirements
- R1: Record k (k = 0..7) of a slice takes its bits [31:0] from word k. Its bits [35:32] come from word 8 bits [31-4k : 28-4k], so record 0's nibble is in word 8 bits [31:28] and record 7's is in bits [3:0].
- R2: In a sample record, bits [33:0] are the channel value. The output shows that value for (bit 34 + 1) consecutive beats when bit 35 is clear.
- R3: When bit 35 of a sample record is set, the following record is a length record, even when it lies in the next slice. The sample is then shown for (bit 34 + 1 + 2 × the length record's 36-bit value) beats.
- R4: While a length record is pending, out_valid is low. Each length record within a slice costs exactly one idle output cycle.
- R5: After word 8 of a slice is accepted, in_ready stays low until all eight records of that slice have been consumed.
- R6: With max_samples nonzero, exactly min(max_samples, stream total) beats are produced, and limit_hit is high once max_samples beats have been produced. With max_samples zero, every beat is produced and limit_hit stays low.
- R7: While rst is high and right after it, out_valid and limit_hit are 0 and in_ready is 1. A new stream then decodes from its first record as a sample record.
- R8: A new sample record is loaded in the same cycle as the last beat of the previous run. Runs within one slice therefore follow each other with no idle cycle, apart from those caused by R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| max_samples | input | CNT_W (32) | Sample limit, 0 for none; held stable outside reset |
| in_data | input | WORD_W (32) | Packed capture-memory word |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Decoder accepts in_data this cycle |
| out_valid | output | 1 | out_sample carries a sample this beat |
| out_sample | output | CH_W (34) | Decoded channel values |
| limit_hit | output | 1 | max_samples beats have been produced |

## Verification
The closest timing in this block is the last beat of one run and the loading of the next record, which happen in the same clock edge. The same is true of the final permitted beat and the sample limit. The bench provokes the first case with single-slice streams that mix plain and flagged records. It then counts the idle output cycles between the first and last beats, which must equal the number of length records exactly: one extra idle cycle shows a late load, and one too few shows a length record that never stalled output. The second case uses runs of two against an odd limit, so the limit falls mid-run. The bench checks that exactly that many beats appear, each carrying the expected value, and that limit_hit is raised.

// File: rtl/rle_dec_pkg.sv
package rle_dec_pkg;

  // Decoder interpretation of the next record
  typedef enum logic [0:0] {
    ST_SAMPLE = 1'b0,
    ST_LENGTH = 1'b1
  } dec_state_t;

endpackage

// File: rtl/rle_slice_unpack.sv
module rle_slice_unpack #(
  parameter int WORD_W = 32,
  parameter int REC_W  = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              rec_valid,
  output logic [REC_W-1:0]  rec_data,
  input  logic              rec_ready
);

  localparam int NIB_W   = REC_W - WORD_W;
  localparam int SLICE_N = WORD_W / NIB_W;
  localparam int IDX_W   = $clog2(SLICE_N);
  localparam int WR_W    = $clog2(SLICE_N + 1);

  // Low words of the slice: write-only port, asynchronous read (distributed RAM)
  logic [WORD_W-1:0] low_mem [SLICE_N];
  logic [WORD_W-1:0] nib_word;
  logic [WR_W-1:0]   wr_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic              draining;
  logic              accept;
  logic              is_nib_word;
  logic              take;
  logic [WORD_W-1:0] nib_shifted;
  logic [NIB_W-1:0]  rec_nib;

  assign in_ready    = !draining;
  assign accept      = in_valid && in_ready;
  assign is_nib_word = (wr_idx == WR_W'(SLICE_N));
  assign take        = rec_valid && rec_ready;
  assign rec_valid   = draining;

  always_ff @(posedge clk) begin
    if (accept && !is_nib_word) begin
      low_mem[wr_idx[IDX_W-1:0]] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx   <= '0;
      rd_idx   <= '0;
      draining <= 1'b0;
      nib_word <= '0;
    end else begin
      if (accept) begin
        if (is_nib_word) begin
          nib_word <= in_data;
          wr_idx   <= '0;
          rd_idx   <= '0;
          draining <= 1'b1;
        end else begin
          wr_idx <= wr_idx + WR_W'(1);
        end
      end
      if (take) begin
        rd_idx <= rd_idx + IDX_W'(1);
        if (rd_idx == IDX_W'(SLICE_N - 1)) begin
          draining <= 1'b0;
        end
      end
    end
  end

  // Record k's nibble: the packed word shifted so bits [35:32] of (word << 4k+4) land low
  always_comb begin
    int sh;
    sh          = WORD_W - NIB_W * (int'(rd_idx) + 1);
    nib_shifted = nib_word >> sh;
    rec_nib     = nib_shifted[NIB_W-1:0];
    rec_data    = {rec_nib, low_mem[rd_idx]};
  end

  AST_SLICE_LOCK: assert property (@(posedge clk) disable iff (rst)
    (accept && is_nib_word) |=> (rec_valid && !in_ready)); // R5

  AST_SLICE_FREE: assert property (@(posedge clk) disable iff (rst)
    (take && rd_idx == IDX_W'(SLICE_N - 1)) |=> in_ready); // R5

  AST_REC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready) |=> $stable(rec_data)); // R1

endmodule

// File: rtl/rle_run_engine.sv
module rle_run_engine
  import rle_dec_pkg::*;
#(
  parameter int CH_W  = 34,
  parameter int REC_W = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rec_valid,
  input  logic [REC_W-1:0] rec_data,
  output logic             rec_ready,
  input  logic             stop,
  output logic             fire,
  output logic             out_valid,
  output logic [CH_W-1:0]  out_sample
);

  localparam int RUN_W   = REC_W + 2;
  localparam int RUN_BIT = CH_W;
  localparam int EXT_BIT = CH_W + 1;

  dec_state_t        state;
  logic [RUN_W-1:0]  run;
  logic [CH_W-1:0]   cur;
  logic              take;
  logic              last_beat;
  logic [RUN_W-1:0]  base_run;
  logic [RUN_W-1:0]  ext_run;

  assign fire      = (state == ST_SAMPLE) && (run != '0) && !stop;
  assign last_beat = fire && (run == RUN_W'(1));
  assign rec_ready = !stop && ((state == ST_LENGTH) || (run == '0) || last_beat);
  assign take      = rec_valid && rec_ready;
  assign base_run  = {{(RUN_W-2){1'b0}}, 2'(rec_data[RUN_BIT]) + 2'd1};
  assign ext_run   = {1'b0, rec_data, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_SAMPLE;
      run        <= '0;
      cur        <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_sample <= cur;
      end
      if (take) begin
        if (state == ST_SAMPLE) begin
          cur   <= rec_data[CH_W-1:0];
          run   <= base_run;
          state <= rec_data[EXT_BIT] ? ST_LENGTH : ST_SAMPLE;
        end else begin
          run   <= run + ext_run;
          state <= ST_SAMPLE;
        end
      end else if (fire) begin
        run <= run - RUN_W'(1);
      end
    end
  end

  AST_LEN_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LENGTH) |=> !out_valid); // R4

  AST_RUN_STEP: assert property (@(posedge clk) disable iff (rst)
    (fire && !take) |=> (run == $past(run) - RUN_W'(1))); // R2

  AST_FLAG_TO_LEN: assert property (@(posedge clk) disable iff (rst)
    (take && state == ST_SAMPLE && rec_data[EXT_BIT]) |=> (state == ST_LENGTH)); // R3

  AST_LEN_RETURN: assert property (@(posedge clk) disable iff (rst)
    (take && state == ST_LENGTH) |=> (state == ST_SAMPLE && run >= $past(run))); // R3

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (last_beat && rec_valid) |=> (run != '0 || state == ST_LENGTH)); // R8

endmodule

// File: rtl/rle_emit_counter.sv
module rle_emit_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [CNT_W-1:0] max_samples,
  output logic             hit
);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (fire) begin
      count <= count + CNT_W'(1);
    end
  end

  assign hit = (max_samples != '0) && (count >= max_samples);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    fire |=> (count == $past(count) + CNT_W'(1))); // R6

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    hit |=> (count == $past(count))); // R6

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (max_samples != '0) |-> (count <= max_samples)); // R6

endmodule

// File: rtl/rle_stream_decoder.sv
module rle_stream_decoder #(
  parameter int CH_W   = 34,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  max_samples,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_sample,
  output logic              limit_hit
);

  localparam int REC_W = CH_W + 2;

  logic             rec_valid;
  logic [REC_W-1:0] rec_data;
  logic             rec_ready;
  logic             fire;

  rle_slice_unpack #(
    .WORD_W (WORD_W),
    .REC_W  (REC_W)
  ) u_unpack (
    .clk       (clk),
    .rst       (rst),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .rec_valid (rec_valid),
    .rec_data  (rec_data),
    .rec_ready (rec_ready)
  );

  rle_run_engine #(
    .CH_W  (CH_W),
    .REC_W (REC_W)
  ) u_engine (
    .clk        (clk),
    .rst        (rst),
    .rec_valid  (rec_valid),
    .rec_data   (rec_data),
    .rec_ready  (rec_ready),
    .stop       (limit_hit),
    .fire       (fire),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  rle_emit_counter #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk         (clk),
    .rst         (rst),
    .fire        (fire),
    .max_samples (max_samples),
    .hit         (limit_hit)
  );

  AST_QUIET_AFTER_LIMIT: assert property (@(posedge clk) disable iff (rst)
    limit_hit |=> !out_valid); // R6

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready && !limit_hit)); // R7

endmodule

// File: tb/rle_stream_decoder_test.sv
module rle_stream_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] max_samples = '0;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        out_valid;
  logic [33:0] out_sample;
  logic        limit_hit;

  rle_stream_decoder uut (
    .clk         (clk),
    .rst         (rst),
    .max_samples (max_samples),
    .in_data     (in_data),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_sample  (out_sample),
    .limit_hit   (limit_hit)
  );

  always #5 clk = ~clk;

  // Stimulus and expectation storage (written only by the initial block)
  logic [35:0] recs  [0:255];
  logic [33:0] exp_s [0:4095];
  int n_rec, exp_total, exp_flags;
  string cur_tag = "R2";

  int tb_checks = 0, tb_fails = 0;
  int mon_checks = 0, mon_fails = 0;
  int wd_fail = 0;
  int cyc = 0;

  // Output monitor: owns beat index and gap bookkeeping, cleared by reset
  int beat_idx, pend_low, gap_total;
  bit seen_beat;
  always @(negedge clk) begin
    if (rst) begin
      beat_idx = 0; pend_low = 0; gap_total = 0; seen_beat = 0;
    end else if (out_valid) begin
      mon_checks++;
      if (beat_idx >= exp_total) begin
        mon_fails++;
        $display("FAIL %s extra beat %0d: got %h, expected no beat", cur_tag, beat_idx, out_sample);
      end else if (out_sample !== exp_s[beat_idx]) begin
        mon_fails++;
        $display("FAIL %s beat %0d: got %h, expected %h", cur_tag, beat_idx, out_sample, exp_s[beat_idx]);
      end
      if (seen_beat) gap_total += pend_low;
      pend_low = 0; seen_beat = 1; beat_idx++;
    end else if (seen_beat) begin
      pend_low++;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures",
             tb_checks + mon_checks, tb_fails + mon_fails + wd_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      wd_fail = 1;
      $display("FAIL watchdog: got %0d cycles, expected under 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint got, input longint want);
    tb_checks++;
    if (!ok) begin
      tb_fails++;
      $display("FAIL %s: got %0d, expected %0d", tag, got, want);
    end
  endtask

  task automatic add_rec(input logic [35:0] r);
    recs[n_rec] = r;
    n_rec++;
  endtask

  task automatic add_plain(input logic [33:0] s, input bit b34);
    add_rec({1'b0, b34, s});
  endtask

  task automatic add_flag(input logic [33:0] s, input bit b34, input logic [35:0] len);
    add_rec({1'b1, b34, s});
    add_rec(len);
  endtask

  // Arithmetic expansion of the record list (R2, R3, R6)
  task automatic build_expected(input int limit);
    int j = 0;
    exp_total = 0; exp_flags = 0;
    while (j < n_rec) begin
      logic [35:0] r = recs[j];
      longint n = longint'(r[34]) + 1;
      if (r[35]) begin
        n += 2 * longint'(recs[j+1]);
        exp_flags++;
        j++;
      end
      for (longint m = 0; m < n; m++) begin
        if (limit == 0 || exp_total < limit) begin
          exp_s[exp_total] = r[33:0];
          exp_total++;
        end
      end
      j++;
    end
  endtask

  task automatic send_slice(input int base);
    logic [31:0] nibs = '0;
    for (int k = 0; k < 8; k++) begin
      nibs |= 32'(recs[base+k][35:32]) << (28 - 4*k); // R1 packing
    end
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      in_data  = (k < 8) ? recs[base+k][31:0] : nibs;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R5 in_ready after word 8", longint'(in_ready), 0);
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 40) begin
      @(negedge clk);
      if (out_valid) q = 0; else q++;
    end
  endtask

  task automatic run_case(input int limit, input bit gap_chk, input string tag);
    rst = 1'b1;
    max_samples = 32'(limit);
    cur_tag = tag;
    build_expected(limit);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1 && limit_hit == 1'b0, "R7 reset state",
          longint'({out_valid, in_ready, limit_hit}), 2);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R7 after reset",
          longint'({out_valid, in_ready}), 1);
    for (int b = 0; b < n_rec; b += 8) send_slice(b);
    wait_idle();
    check(beat_idx == exp_total, {tag, " R6 beat count"}, beat_idx, exp_total);
    check(in_ready == 1'b1 || limit_hit, "R5 in_ready after drain", longint'(in_ready), 1);
    check(limit_hit == (limit != 0 && exp_total >= limit), "R6 limit_hit",
          longint'(limit_hit), longint'(limit != 0 && exp_total >= limit));
    if (gap_chk) begin
      check(gap_total == exp_flags, "R4 R8 idle cycles between beats", gap_total, exp_flags);
    end
  endtask

  initial begin
    // Gap case: two length records in one slice (R4, R8)
    n_rec = 0;
    add_plain(34'h3_0000_0011, 1'b1);
    add_flag (34'h1_8000_0022, 1'b1, 36'd2);
    add_plain(34'h2_4000_0033, 1'b0);
    add_flag (34'h0_1234_5678, 1'b0, 36'd0);
    add_plain(34'h3_FFFF_FFFF, 1'b1);
    add_plain(34'h0_0000_0000, 1'b0);
    run_case(0, 1'b1, "R4");

    // Near-exhaustive sweep of run bit, flag and short lengths (R1, R2, R3)
    n_rec = 0;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] lo = 32'h9E3779B9 * 32'(i + 1);
      logic [33:0] s  = {2'(i), lo};
      if (i % 3 == 0) add_flag(s, i[2], 36'((i * 7) % 5));
      else            add_plain(s, i[2]);
    end
    while (n_rec % 8 != 0) add_plain(34'(n_rec) ^ 34'h2_AAAA_5555, n_rec[0]);
    run_case(0, 1'b0, "R1");

    // Long extension and extension spanning a slice boundary (R3)
    n_rec = 0;
    add_flag(34'h1_DEAD_BEEF, 1'b1, 36'd200);
    for (int i = 0; i < 5; i++) add_plain(34'h2_0000_0100 + 34'(i), i[0]);
    add_flag(34'h3_C0DE_0007, 1'b0, 36'd3);
    for (int i = 0; i < 7; i++) add_plain(34'h0_5A5A_0000 + 34'(i), ~i[0]);
    run_case(0, 1'b0, "R3");

    // Limit falling mid-run (R6)
    n_rec = 0;
    for (int i = 0; i < 24; i++) add_plain(34'h1_0000_0000 | 34'(i * 3), 1'b1);
    run_case(37, 1'b0, "R6");

    // Limit above total: everything emitted, limit not reached (R6)
    n_rec = 0;
    for (int i = 0; i < 8; i++) add_plain(34'h2_1111_0000 + 34'(i), i[1]);
    run_case(100, 1'b0, "R6");

    summary();
    $finish;
  end

endmodule